// File: doc/BRIEF.md
# Dual-Bank CPU Register File

This block holds the general-purpose register state of a 16-bit microcontroller core. Seven 16-bit registers are kept twice, once per bank: four data registers, two address registers and one frame register. A bank flag picks the copy that every access uses. Two of the data registers can also be reached as separate high and low bytes. Two fixed pairs of data registers can be reached as one 32-bit value.

Two stack pointers sit outside the banks: a user pointer and an interrupt pointer. A stack flag picks which one the stack port reads and writes. Both flags are sampled into the block on the clock edge, so a change applies to the access cycle after the edge that captured it.

The write ports are synchronous and the read ports are combinational. Control pins are plain: the file accepts a write in every cycle and never applies back-pressure.

Top module: `dual_bank_regfile`

## Requirements
- R1: After reset every banked register in both banks and both stack pointers read 0. Bank 0 and the interrupt stack pointer are selected.
- R2: A word access (size code 2) to register id 0..6 writes or reads all 16 bits of that register in the active bank, zero-extended on read. Ids 0..3 are the data registers, 4..5 the address registers and 6 the frame register. Id 7 is illegal for every size.
- R3: Byte accesses are allowed on ids 0 and 1 only. Size code 0 selects the low byte and size code 1 the high byte. Write data comes from bits 7:0. A byte write leaves the other half unchanged, and a byte read returns the selected byte zero-extended.
- R4: An illegal access raises wr_illegal_o or rd_illegal_o in the same cycle and changes no register. The read data of an illegal read is 0.
- R5: A 32-bit access (size code 3) with id 0 uses register 2 as bits 31:16 and register 0 as bits 15:0. Id 1 uses register 3 and register 1 the same way. A 32-bit write updates both halves at the same edge. A 32-bit access with any other id is illegal.
- R6: The bank flag is captured at a clock edge and steers every access in the following cycles. The inactive bank keeps its contents.
- R7: A read in the same cycle as a write to the same register returns the value from before the write. The new value appears from the next cycle.
- R8: The stack flag is captured at a clock edge: 1 selects the interrupt pointer and 0 selects the user pointer. The stack port reads and writes only the selected pointer.
- R9: A stack write leaves the unselected stack pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bank_sel_i | input | 1 | Bank flag, captured each edge |
| stk_sel_i | input | 1 | Stack flag, 1 = interrupt pointer, captured each edge |
| wr_en_i | input | 1 | Register write strobe |
| wr_id_i | input | 3 | Register id of the write |
| wr_size_i | input | 2 | Write size code (0 low byte, 1 high byte, 2 word, 3 long) |
| wr_data_i | input | 32 | Write data |
| wr_illegal_o | output | 1 | Write request is illegal and was dropped |
| rd_id_i | input | 3 | Register id of the read |
| rd_size_i | input | 2 | Read size code |
| rd_data_o | output | 32 | Read data, zero-extended |
| rd_illegal_o | output | 1 | Read request is illegal |
| sp_wr_en_i | input | 1 | Stack pointer write strobe |
| sp_wr_data_i | input | 16 | Stack pointer write data |
| sp_rd_data_o | output | 16 | Selected stack pointer |

## Verification
A corrupted register or a write that lands in the wrong bank or half shows on rd_data_o on the first read of the affected location. That read can come one cycle after the faulty edge, so the bench reads back after each write and after each bank switch. A stale captured flag shows as the wrong bank's data, or as the wrong stack pointer on sp_rd_data_o, in the cycle after the flag changes. A dropped or misrouted illegal access shows as a changed value on the following read.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int DW     = 16;
  localparam int NREG   = 7;
  localparam int ID_W   = 3;
  localparam int NBANK  = 2;
  localparam int HALF   = DW / 2;
  localparam int NPAIR  = 2;

  typedef enum logic [1:0] {
    SZ_BLO  = 2'd0,
    SZ_BHI  = 2'd1,
    SZ_WORD = 2'd2,
    SZ_LONG = 2'd3
  } size_e;

  typedef logic [NREG-1:0][DW-1:0] regset_t;

  function automatic logic access_bad(input logic [ID_W-1:0] id, input logic [1:0] sz);
    logic bad;
    bad = (int'(id) >= NREG);
    if (sz != SZ_WORD && int'(id) >= NPAIR) bad = 1'b1;
    return bad;
  endfunction
endpackage

// File: rtl/rf_wr_decode.sv
module rf_wr_decode
  import rf_pkg::*;
(
  input  logic              en_i,
  input  logic [ID_W-1:0]   id_i,
  input  logic [1:0]        size_i,
  input  logic [2*DW-1:0]   data_i,
  output logic [NREG-1:0]   we_lo_o,
  output logic [NREG-1:0]   we_hi_o,
  output regset_t           wval_o,
  output logic              illegal_o
);
  logic bad;
  int   idx;

  always_comb begin
    bad       = access_bad(id_i, size_i);
    idx       = int'(id_i);
    we_lo_o   = '0;
    we_hi_o   = '0;
    wval_o    = '0;
    illegal_o = en_i && bad;
    if (en_i && !bad) begin
      case (size_e'(size_i))
        SZ_WORD: begin
          we_lo_o[idx] = 1'b1;
          we_hi_o[idx] = 1'b1;
          wval_o[idx]  = data_i[DW-1:0];
        end
        SZ_BLO: begin
          we_lo_o[idx] = 1'b1;
          wval_o[idx]  = {2{data_i[HALF-1:0]}};
        end
        SZ_BHI: begin
          we_hi_o[idx] = 1'b1;
          wval_o[idx]  = {2{data_i[HALF-1:0]}};
        end
        default: begin
          we_lo_o[idx]       = 1'b1;
          we_hi_o[idx]       = 1'b1;
          wval_o[idx]        = data_i[DW-1:0];
          we_lo_o[idx+NPAIR] = 1'b1;
          we_hi_o[idx+NPAIR] = 1'b1;
          wval_o[idx+NPAIR]  = data_i[2*DW-1:DW];
        end
      endcase
    end
  end

  always_comb begin
    if (illegal_o) begin
      assert_illegal_no_enable_R4: assert ((we_lo_o | we_hi_o) == '0)
        else $error("illegal write still enables a register");
    end
    if (en_i && !bad && size_i == SZ_LONG) begin
      assert_long_four_halves_R5: assert ($countones({we_lo_o, we_hi_o}) == 4)
        else $error("long write does not enable both registers of the pair");
    end
  end
endmodule

// File: rtl/rf_bank.sv
module rf_bank
  import rf_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            act_i,
  input  logic [NREG-1:0] we_lo_i,
  input  logic [NREG-1:0] we_hi_i,
  input  regset_t         wval_i,
  output regset_t         regs_o
);
  regset_t mem_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_q <= '0;
    end else if (act_i) begin
      for (int i = 0; i < NREG; i++) begin
        if (we_lo_i[i]) mem_q[i][HALF-1:0]  <= wval_i[i][HALF-1:0];
        if (we_hi_i[i]) mem_q[i][DW-1:HALF] <= wval_i[i][DW-1:HALF];
      end
    end
  end

  assign regs_o = mem_q;

  assert_idle_bank_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !act_i |=> $stable(mem_q))
    else $error("inactive bank changed");

  assert_lo_byte_keeps_hi_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (act_i && we_lo_i[0] && !we_hi_i[0]) |=> $stable(mem_q[0][DW-1:HALF]))
    else $error("low byte write disturbed the high byte");
endmodule

// File: rtl/rf_rd_mux.sv
module rf_rd_mux
  import rf_pkg::*;
(
  input  regset_t          regs_i,
  input  logic [ID_W-1:0]  id_i,
  input  logic [1:0]       size_i,
  output logic [2*DW-1:0]  data_o,
  output logic             illegal_o
);
  int idx;

  always_comb begin
    idx       = int'(id_i);
    illegal_o = access_bad(id_i, size_i);
    data_o    = '0;
    if (!illegal_o) begin
      case (size_e'(size_i))
        SZ_WORD: data_o[DW-1:0]   = regs_i[idx];
        SZ_BLO:  data_o[HALF-1:0] = regs_i[idx][HALF-1:0];
        SZ_BHI:  data_o[HALF-1:0] = regs_i[idx][DW-1:HALF];
        default: data_o           = {regs_i[idx+NPAIR], regs_i[idx]};
      endcase
    end
  end
endmodule

// File: rtl/rf_stack_ptrs.sv
module rf_stack_ptrs
  import rf_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          irq_sel_i,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  output logic [DW-1:0] rd_data_o
);
  logic [DW-1:0] usr_q, irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      usr_q <= '0;
      irq_q <= '0;
    end else if (wr_en_i) begin
      if (irq_sel_i) irq_q <= wr_data_i;
      else           usr_q <= wr_data_i;
    end
  end

  assign rd_data_o = irq_sel_i ? irq_q : usr_q;

  assert_idle_usr_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && irq_sel_i) |=> $stable(usr_q))
    else $error("user pointer changed on interrupt pointer write");

  assert_idle_irq_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !irq_sel_i) |=> $stable(irq_q))
    else $error("interrupt pointer changed on user pointer write");
endmodule

// File: rtl/dual_bank_regfile.sv
module dual_bank_regfile
  import rf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bank_sel_i,
  input  logic              stk_sel_i,
  input  logic              wr_en_i,
  input  logic [ID_W-1:0]   wr_id_i,
  input  logic [1:0]        wr_size_i,
  input  logic [2*DW-1:0]   wr_data_i,
  output logic              wr_illegal_o,
  input  logic [ID_W-1:0]   rd_id_i,
  input  logic [1:0]        rd_size_i,
  output logic [2*DW-1:0]   rd_data_o,
  output logic              rd_illegal_o,
  input  logic              sp_wr_en_i,
  input  logic [DW-1:0]     sp_wr_data_i,
  output logic [DW-1:0]     sp_rd_data_o
);
  localparam int BSEL_W = $clog2(NBANK);

  logic [BSEL_W-1:0] bank_q;
  logic              stk_q;
  logic [NREG-1:0]   we_lo, we_hi;
  regset_t           wval;
  regset_t           regs_all [NBANK];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= '0;
      stk_q  <= 1'b1;
    end else begin
      bank_q <= BSEL_W'(bank_sel_i);
      stk_q  <= stk_sel_i;
    end
  end

  rf_wr_decode u_dec (
    .en_i      (wr_en_i),
    .id_i      (wr_id_i),
    .size_i    (wr_size_i),
    .data_i    (wr_data_i),
    .we_lo_o   (we_lo),
    .we_hi_o   (we_hi),
    .wval_o    (wval),
    .illegal_o (wr_illegal_o)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    rf_bank u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .act_i   (bank_q == BSEL_W'(b)),
      .we_lo_i (we_lo),
      .we_hi_i (we_hi),
      .wval_i  (wval),
      .regs_o  (regs_all[b])
    );
  end

  rf_rd_mux u_rd (
    .regs_i    (regs_all[bank_q]),
    .id_i      (rd_id_i),
    .size_i    (rd_size_i),
    .data_o    (rd_data_o),
    .illegal_o (rd_illegal_o)
  );

  rf_stack_ptrs u_sp (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_sel_i (stk_q),
    .wr_en_i   (sp_wr_en_i),
    .wr_data_i (sp_wr_data_i),
    .rd_data_o (sp_rd_data_o)
  );

  assert_flag_follows_input_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_sel_i && $past(rst_n)) |=> (bank_q == BSEL_W'(1)))
    else $error("bank flag not captured");

  assert_illegal_write_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_illegal_o && !sp_wr_en_i) |=> $stable(regs_all[0]) && $stable(regs_all[1]))
    else $error("illegal write changed a register");
endmodule

// File: tb/test_dual_bank_regfile.sv
`timescale 1ns/1ps
module test_dual_bank_regfile;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bank_sel_i = 1'b0, stk_sel_i = 1'b1;
  logic        wr_en_i = 1'b0;
  logic [2:0]  wr_id_i = '0;
  logic [1:0]  wr_size_i = '0;
  logic [31:0] wr_data_i = '0;
  logic        wr_illegal_o;
  logic [2:0]  rd_id_i = '0;
  logic [1:0]  rd_size_i = 2'd2;
  logic [31:0] rd_data_o;
  logic        rd_illegal_o;
  logic        sp_wr_en_i = 1'b0;
  logic [15:0] sp_wr_data_i = '0;
  logic [15:0] sp_rd_data_o;

  always #10 clk = ~clk;

  dual_bank_regfile i_dual_bank_regfile (
    .clk(clk), .rst_n(rst_n), .bank_sel_i(bank_sel_i), .stk_sel_i(stk_sel_i),
    .wr_en_i(wr_en_i), .wr_id_i(wr_id_i), .wr_size_i(wr_size_i), .wr_data_i(wr_data_i),
    .wr_illegal_o(wr_illegal_o), .rd_id_i(rd_id_i), .rd_size_i(rd_size_i),
    .rd_data_o(rd_data_o), .rd_illegal_o(rd_illegal_o), .sp_wr_en_i(sp_wr_en_i),
    .sp_wr_data_i(sp_wr_data_i), .sp_rd_data_o(sp_rd_data_o)
  );

  typedef struct {
    logic [31:0] rd;
    logic        rill;
    logic        will;
    logic [15:0] sp;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  int          nchk = 0, nfail = 0;
  bit          done = 0;
  logic [15:0] m [2][7];
  logic [15:0] msp [2];
  int          cur_bank = 0, cur_stk = 1;

  function automatic bit bad_acc(input logic [2:0] id, input logic [1:0] sz);
    return (id == 3'd7) || (sz != 2'd2 && id > 3'd1);
  endfunction

  // Scoreboard monitor: one expected item per checked cycle, compared mid-cycle
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      nchk++;
      if (rd_data_o !== e.rd || rd_illegal_o !== e.rill ||
          wr_illegal_o !== e.will || sp_rd_data_o !== e.sp) begin
        nfail++;
        $display("FAIL %s: rd=%h rill=%b will=%b sp=%h expected rd=%h rill=%b will=%b sp=%h",
                 e.tag, rd_data_o, rd_illegal_o, wr_illegal_o, sp_rd_data_o,
                 e.rd, e.rill, e.will, e.sp);
      end
    end
  end

  // Driver: one cycle of stimulus, expectation pushed from the bench model
  task automatic step(input bit wen, input logic [2:0] wid, input logic [1:0] wsz,
                      input logic [31:0] wd, input logic [2:0] rid, input logic [1:0] rsz,
                      input bit spw, input logic [15:0] spd, input string tag);
    exp_t e;
    wr_en_i = wen; wr_id_i = wid; wr_size_i = wsz; wr_data_i = wd;
    rd_id_i = rid; rd_size_i = rsz; sp_wr_en_i = spw; sp_wr_data_i = spd;
    e.rill = bad_acc(rid, rsz);
    e.will = wen && bad_acc(wid, wsz);
    e.rd   = '0;
    if (!e.rill) begin
      case (rsz)
        2'd0: e.rd = {24'd0, m[cur_bank][rid][7:0]};
        2'd1: e.rd = {24'd0, m[cur_bank][rid][15:8]};
        2'd2: e.rd = {16'd0, m[cur_bank][rid]};
        default: e.rd = {m[cur_bank][rid+2], m[cur_bank][rid]};
      endcase
    end
    e.sp  = msp[cur_stk];
    e.tag = tag;
    sb.push_back(e);
    @(posedge clk);
    if (wen && !e.will) begin
      case (wsz)
        2'd0: m[cur_bank][wid][7:0]  = wd[7:0];
        2'd1: m[cur_bank][wid][15:8] = wd[7:0];
        2'd2: m[cur_bank][wid]       = wd[15:0];
        default: begin
          m[cur_bank][wid]   = wd[15:0];
          m[cur_bank][wid+2] = wd[31:16];
        end
      endcase
    end
    if (spw) msp[cur_stk] = spd;
    cur_bank = int'(bank_sel_i);
    cur_stk  = int'(stk_sel_i);
    #1;
  endtask

  task automatic rd(input logic [2:0] id, input logic [1:0] sz, input string tag);
    step(0, 3'd0, 2'd2, 32'd0, id, sz, 0, 16'd0, tag);
  endtask

  task automatic wr(input logic [2:0] id, input logic [1:0] sz, input logic [31:0] d,
                    input string tag);
    step(1, id, sz, d, id, sz, 0, 16'd0, tag);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < 2; b++) begin
      msp[b] = '0;
      for (int i = 0; i < 7; i++) m[b][i] = '0;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset contents and selection
    for (int i = 0; i < 7; i++) rd(3'(i), 2'd2, "R1 reset bank0");
    // R2: word write then read each register, then id 7
    for (int i = 0; i < 7; i++) wr(3'(i), 2'd2, 32'h0000_1100 + 32'(i * 17), "R2 word wr");
    for (int i = 0; i < 7; i++) rd(3'(i), 2'd2, "R2 word rd");
    wr(3'd7, 2'd2, 32'h0000_BEEF, "R2 id7 illegal");
    // R3: byte halves on ids 0 and 1
    wr(3'd0, 2'd0, 32'h0000_00AB, "R3 lo byte wr");
    rd(3'd0, 2'd2, "R3 lo byte keeps hi");
    wr(3'd1, 2'd1, 32'h0000_00CD, "R3 hi byte wr");
    rd(3'd1, 2'd2, "R3 hi byte keeps lo");
    rd(3'd1, 2'd1, "R3 hi byte rd");
    rd(3'd0, 2'd0, "R3 lo byte rd");
    // R4: byte access to non-byte registers
    for (int i = 2; i < 7; i++) begin
      wr(3'(i), 2'd0, 32'h0000_0055, "R4 byte illegal");
      rd(3'(i), 2'd2, "R4 unchanged");
    end
    // R5: 32-bit pairs
    wr(3'd0, 2'd3, 32'hDEAD_BEEF, "R5 long id0");
    rd(3'd2, 2'd2, "R5 upper half reg2");
    rd(3'd0, 2'd3, "R5 long rd id0");
    wr(3'd1, 2'd3, 32'hCAFE_F00D, "R5 long id1");
    rd(3'd3, 2'd2, "R5 upper half reg3");
    rd(3'd1, 2'd3, "R5 long rd id1");
    wr(3'd4, 2'd3, 32'h1234_5678, "R5 long illegal id4");
    rd(3'd4, 2'd2, "R5 id4 unchanged");
    // R6: switch banks
    bank_sel_i = 1'b1;
    rd(3'd0, 2'd2, "R6 capture edge");
    rd(3'd0, 2'd2, "R6 bank1 empty");
    wr(3'd0, 2'd2, 32'h0000_7777, "R6 bank1 wr");
    wr(3'd6, 2'd2, 32'h0000_6666, "R6 bank1 wr frame");
    bank_sel_i = 1'b0;
    rd(3'd0, 2'd2, "R6 capture back");
    for (int i = 0; i < 7; i++) rd(3'(i), 2'd2, "R6 bank0 kept");
    bank_sel_i = 1'b1;
    rd(3'd6, 2'd2, "R6 capture again");
    rd(3'd6, 2'd2, "R6 bank1 kept");
    bank_sel_i = 1'b0;
    rd(3'd0, 2'd2, "R6 return bank0");
    // R7: same-cycle read sees old value
    step(1, 3'd5, 2'd2, 32'h0000_9999, 3'd5, 2'd2, 0, 16'd0, "R7 old value");
    rd(3'd5, 2'd2, "R7 new value next");
    step(1, 3'd0, 2'd3, 32'h0102_0304, 3'd0, 2'd3, 0, 16'd0, "R7 long old value");
    rd(3'd0, 2'd3, "R7 long new value");
    // R8/R9: stack pointers
    step(0, 3'd0, 2'd2, 32'd0, 3'd0, 2'd2, 1, 16'hA5A5, "R8 irq sp wr");
    rd(3'd0, 2'd2, "R8 irq sp rd");
    stk_sel_i = 1'b0;
    rd(3'd0, 2'd2, "R8 capture stack flag");
    rd(3'd0, 2'd2, "R9 user sp untouched");
    step(0, 3'd0, 2'd2, 32'd0, 3'd0, 2'd2, 1, 16'h3C3C, "R8 user sp wr");
    rd(3'd0, 2'd2, "R8 user sp rd");
    stk_sel_i = 1'b1;
    rd(3'd0, 2'd2, "R8 capture back");
    rd(3'd0, 2'd2, "R9 irq sp kept");
    // R1: reset again restores zero and default selection
    bank_sel_i = 1'b1;
    rd(3'd0, 2'd2, "R1 pre-reset");
    rst_n = 1'b0;
    for (int b = 0; b < 2; b++) begin
      msp[b] = '0;
      for (int i = 0; i < 7; i++) m[b][i] = '0;
    end
    bank_sel_i = 1'b0; stk_sel_i = 1'b1;
    cur_bank = 0; cur_stk = 1;
    @(posedge clk); #1 rst_n = 1'b1;
    rd(3'd0, 2'd3, "R1 after reset long");
    rd(3'd6, 2'd2, "R1 after reset frame");

    @(negedge clk);
    @(posedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule